// File: doc/BRIEF.md
# Carrier-Gap Interval Frame Decoder

This block recovers bit frames sent by a low-frequency reader that signals by briefly gapping its carrier. The input is a demodulated, thresholded field indication, asynchronous to the system clock. After synchronising it, the block measures the time between consecutive rising edges in carrier periods and sorts each interval into a 0 bit, a 1 bit or noise. Recovered bits are packed into a frame buffer, first bit in the most significant position.

A long silence on the line closes the frame. If any bit was gathered, the block presents the frame with its bit count for one cycle and then starts afresh. The interval counter keeps running after the end of frame and is exported, so that a responder can time its reply from the last reader edge. Because that counter wraps, the interval that spans an end-of-frame timeout is thrown away.

Top module: `lf_gap_decoder`

## Requirements
- R1: One carrier period lasts `carrier_div`+1 system clocks. `since_edge` counts the carrier periods completed since the last detected rising edge. It restarts at 0 on every edge, together with the period prescaler, and wraps modulo 256.
- R2: `field_in` passes through a two-flop synchroniser. A rising edge is detected by comparing the synchronised value with a one-cycle delayed copy. Each detected rising edge ends one interval and starts the next.
- R3: An interval of fewer than 15 carrier periods is noise. It adds no bit, but its edge still starts a new interval.
- R4: An interval of 15 to 23 carrier periods, inclusive, adds a 0 bit.
- R5: An interval of 24 to 40 carrier periods, inclusive, adds a 1 bit.
- R6: When `since_edge` goes past 40, the frame ends. If at least one bit was collected, `frame_valid` pulses high for exactly one cycle. `frame_bits` and `frame_len` then hold that frame until the next delivery. The internal buffer and bit count are cleared in either case.
- R7: An end of frame with no collected bits produces no pulse and leaves `frame_bits` and `frame_len` unchanged.
- R8: After an end of frame, the next interval is ignored whatever its length, because the counter may have wrapped. The edge that ends that interval clears the ignore condition.
- R9: Bit k of a frame (k = 0 for the first bit) is placed at `frame_bits[79-k]`. Positions past `frame_len` read 0.
- R10: At most 80 bits are kept. Further bits are dropped silently, and `frame_len` reports 80.
- R11: While `rst_n` is low, `frame_valid`, `frame_bits`, `frame_len` and `since_edge` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| carrier_div | input | 8 | Carrier period length minus one, in system clocks |
| field_in | input | 1 | Thresholded reader field, asynchronous |
| frame_valid | output | 1 | One-cycle pulse when a frame is delivered |
| frame_bits | output | 80 | Delivered frame, first bit at the MSB |
| frame_len | output | 7 | Number of valid bits in `frame_bits` |
| since_edge | output | 8 | Carrier periods since the last rising edge |

## Verification
The bench places edges exactly at the class boundaries 14/15, 23/24 and 40. A comparator off by one turns a noise gap into a bit, or flips a 0 into a 1. It sends noise edges inside a frame; a design that forgets to restart the interval on a noise edge mis-decodes the next bit. A silence longer than the counter range, ending in a wrapped interval that looks like a valid 0, exposes a design that does not discard the interval across the timeout. Frames of 82 bits, an empty frame, and a second carrier divisor check truncation, the rule that nothing is delivered for an empty frame, and the period scaling.

// File: rtl/lfgd_pkg.sv
package lfgd_pkg;

  typedef enum logic [1:0] {
    SYM_NOISE = 2'd0,
    SYM_ZERO  = 2'd1,
    SYM_ONE   = 2'd2
  } sym_e;

  // Sort one measured interval (in carrier periods) into a symbol class.
  function automatic sym_e classify(input int unsigned ival,
                                    input int unsigned zero_min,
                                    input int unsigned one_min,
                                    input int unsigned upper_lim);
    if (ival < zero_min || ival > upper_lim) return SYM_NOISE;
    else if (ival < one_min)                 return SYM_ZERO;
    else                                     return SYM_ONE;
  endfunction

endpackage

// File: rtl/lfgd_edge_sync.sv
module lfgd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;

  assign sync_d[0] = din;
  for (genvar g = 1; g < STAGES; g++) begin : g_chain
    assign sync_d[g] = sync_q[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;

  // R2: a detected edge never lasts two cycles
  a_r2_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/lfgd_interval_timer.sv
module lfgd_interval_timer #(
  parameter int DIV_W     = 8,
  parameter int CNT_W     = 8,
  parameter int EOF_LIMIT = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             rise,
  output logic [CNT_W-1:0] count,
  output logic             eof
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(EOF_LIMIT);

  logic [DIV_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick;

  assign tick = (pre_q >= div);

  always_comb begin
    pre_d = pre_q;
    cnt_d = cnt_q;
    if (rise) begin
      pre_d = '0;
      cnt_d = '0;
    end else if (tick) begin
      pre_d = '0;
      cnt_d = cnt_q + 1'b1;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;
  assign eof   = tick & ~rise & (cnt_q == LIMIT);

  // R1: without an edge the count holds or advances by exactly one
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> (count == $past(count) || count == $past(count) + 1'b1));

  // R1: every edge restarts the count
  a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> count == '0);

  // R6: end of frame leaves the count just past the limit
  a_r6_eof_past_limit: assert property (@(posedge clk) disable iff (!rst_n)
    eof |=> count == LIMIT + 1'b1);

endmodule

// File: rtl/lfgd_frame_builder.sv
module lfgd_frame_builder
  import lfgd_pkg::*;
#(
  parameter int FRAME_BITS = 80,
  parameter int LEN_W      = 7,
  parameter int CNT_W      = 8,
  parameter int ZERO_MIN   = 15,
  parameter int ONE_MIN    = 24,
  parameter int EOF_LIMIT  = 40
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rise,
  input  logic [CNT_W-1:0]      interval,
  input  logic                  eof,
  output logic                  frame_valid,
  output logic [FRAME_BITS-1:0] frame_bits,
  output logic [LEN_W-1:0]      frame_len
);

  localparam logic [LEN_W-1:0] FULL = LEN_W'(FRAME_BITS);

  logic [FRAME_BITS-1:0] buf_q, buf_d, obits_q, obits_d;
  logic [LEN_W-1:0]      cnt_q, cnt_d, olen_q, olen_d;
  logic                  ovf_q, ovf_d, valid_q, valid_d;
  sym_e                  sym;

  assign sym = classify(32'(interval), ZERO_MIN, ONE_MIN, EOF_LIMIT);

  always_comb begin
    buf_d   = buf_q;
    cnt_d   = cnt_q;
    ovf_d   = ovf_q;
    valid_d = 1'b0;
    obits_d = obits_q;
    olen_d  = olen_q;
    if (eof) begin
      ovf_d = 1'b1;
      if (cnt_q != '0) begin
        valid_d = 1'b1;
        obits_d = buf_q;
        olen_d  = cnt_q;
      end
      buf_d = '0;
      cnt_d = '0;
    end else if (rise) begin
      ovf_d = 1'b0;
      if (!ovf_q && sym != SYM_NOISE && cnt_q < FULL) begin
        buf_d[FRAME_BITS-1-int'(cnt_q)] = (sym == SYM_ONE);
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '0;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
      valid_q <= 1'b0;
      obits_q <= '0;
      olen_q  <= '0;
    end else begin
      buf_q   <= buf_d;
      cnt_q   <= cnt_d;
      ovf_q   <= ovf_d;
      valid_q <= valid_d;
      obits_q <= obits_d;
      olen_q  <= olen_d;
    end
  end

  assign frame_valid = valid_q;
  assign frame_bits  = obits_q;
  assign frame_len   = olen_q;

  // R7: a delivered frame is never empty
  a_r7_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> frame_len != '0);

  // R6: delivery is a single-cycle pulse
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  // R8: end of frame arms the discard of the next interval
  a_r8_ovf_armed: assert property (@(posedge clk) disable iff (!rst_n)
    eof |=> ovf_q);

  // R8: an interval while armed adds no bit
  a_r8_no_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && ovf_q) |=> cnt_q == $past(cnt_q));

  // R10: the bit count never exceeds the buffer
  a_r10_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);

endmodule

// File: rtl/lf_gap_decoder.sv
module lf_gap_decoder #(
  parameter int DIV_W       = 8,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS  = 80,
  parameter int ZERO_MIN    = 15,
  parameter int ONE_MIN     = 24,
  parameter int EOF_LIMIT   = 40,
  localparam int LEN_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DIV_W-1:0]      carrier_div,
  input  logic                  field_in,
  output logic                  frame_valid,
  output logic [FRAME_BITS-1:0] frame_bits,
  output logic [LEN_W-1:0]      frame_len,
  output logic [CNT_W-1:0]      since_edge
);

  logic             rise;
  logic             eof;
  logic [CNT_W-1:0] count;

  lfgd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (field_in),
    .rise (rise)
  );

  lfgd_interval_timer #(
    .DIV_W    (DIV_W),
    .CNT_W    (CNT_W),
    .EOF_LIMIT(EOF_LIMIT)
  ) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .div  (carrier_div),
    .rise (rise),
    .count(count),
    .eof  (eof)
  );

  lfgd_frame_builder #(
    .FRAME_BITS(FRAME_BITS),
    .LEN_W     (LEN_W),
    .CNT_W     (CNT_W),
    .ZERO_MIN  (ZERO_MIN),
    .ONE_MIN   (ONE_MIN),
    .EOF_LIMIT (EOF_LIMIT)
  ) u_build (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise       (rise),
    .interval   (count),
    .eof        (eof),
    .frame_valid(frame_valid),
    .frame_bits (frame_bits),
    .frame_len  (frame_len)
  );

  assign since_edge = count;

endmodule

// File: tb/lf_gap_decoder_tb.sv
module lf_gap_decoder_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  carrier_div;
  logic        field_in;
  logic        frame_valid;
  logic [79:0] frame_bits;
  logic [6:0]  frame_len;
  logic [7:0]  since_edge;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  logic [79:0] cap_bits = '0;
  logic [6:0]  cap_len  = '0;
  int ivals [0:89];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lf_gap_decoder dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .carrier_div(carrier_div),
    .field_in   (field_in),
    .frame_valid(frame_valid),
    .frame_bits (frame_bits),
    .frame_len  (frame_len),
    .since_edge (since_edge)
  );

  always @(negedge clk) begin
    if (rst_n && frame_valid) begin
      pulses   <= pulses + 1;
      cap_bits <= frame_bits;
      cap_len  <= frame_len;
    end
  end

  function automatic int per();
    return int'(carrier_div) + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [79:0] act,
                     input logic [79:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse();
    field_in = 1'b1;
    @(negedge clk);
    field_in = 1'b0;
  endtask

  task automatic hold(input int n);
    repeat (n * per() + per() / 2 - 1) @(negedge clk);
  endtask

  task automatic quiet();
    repeat (45 * per() + 4) @(negedge clk);
  endtask

  // start edge, n intervals, then silence
  task automatic run_frame(input int n);
    pulse();
    for (int i = 0; i < n; i++) begin
      hold(ivals[i]);
      pulse();
    end
    quiet();
  endtask

  task automatic expect_frame(input int n, input string req);
    logic [79:0] eb;
    int k;
    eb = '0;
    k = 0;
    for (int i = 0; i < n; i++) begin
      if (ivals[i] >= 15 && ivals[i] <= 40) begin
        if (k < 80) eb[79-k] = (ivals[i] >= 24);
        k++;
      end
    end
    if (k > 80) k = 80;
    chk(cap_len == 7'(k), req, 80'(cap_len), 80'(k));
    chk(cap_bits == eb, req, cap_bits, eb);
  endtask

  task automatic t_reset();
    chk(frame_valid == 1'b0, "R11 valid", 80'(frame_valid), 80'd0);
    chk(frame_len == '0, "R11 len", 80'(frame_len), 80'd0);
    chk(frame_bits == '0, "R11 bits", frame_bits, 80'd0);
    chk(since_edge == '0, "R11 since", 80'(since_edge), 80'd0);
  endtask

  task automatic t_boundaries();
    int p0;
    p0 = pulses;
    ivals[0] = 20; ivals[1] = 30; ivals[2] = 15; ivals[3] = 23;
    ivals[4] = 24; ivals[5] = 40; ivals[6] = 14;
    run_frame(7);
    chk(pulses == p0 + 1, "R6 one pulse", 80'(pulses), 80'(p0 + 1));
    expect_frame(7, "R2 R4 R5 R9 boundaries");
  endtask

  task automatic t_noise();
    int p0;
    p0 = pulses;
    ivals[0] = 30; ivals[1] = 10; ivals[2] = 20; ivals[3] = 5; ivals[4] = 24;
    run_frame(5);
    chk(pulses == p0 + 1, "R3 pulse", 80'(pulses), 80'(p0 + 1));
    expect_frame(5, "R3 noise restart");
  endtask

  task automatic t_empty();
    int p0;
    p0 = pulses;
    ivals[0] = 10;
    run_frame(1);
    chk(pulses == p0, "R7 no pulse", 80'(pulses), 80'(p0));
    chk(frame_len == 7'd3, "R7 len held", 80'(frame_len), 80'd3);
  endtask

  task automatic t_wrap_discard();
    int p0;
    p0 = pulses;
    pulse();
    hold(20);
    pulse();
    hold(276);
    pulse();
    hold(30);
    pulse();
    quiet();
    chk(pulses == p0 + 2, "R8 pulses", 80'(pulses), 80'(p0 + 2));
    chk(cap_len == 7'd1, "R8 len", 80'(cap_len), 80'd1);
    chk(cap_bits == {1'b1, 79'd0}, "R8 bits", cap_bits, {1'b1, 79'd0});
  endtask

  task automatic t_long();
    for (int i = 0; i < 82; i++) ivals[i] = (i % 3 == 0) ? 28 : 18;
    run_frame(82);
    expect_frame(82, "R10 truncate");
  endtask

  task automatic t_since();
    pulse();
    repeat (10 * per() + 2) @(negedge clk);
    chk(since_edge == 8'd10, "R1 count", 80'(since_edge), 80'd10);
    repeat (250 * per()) @(negedge clk);
    chk(since_edge == 8'd4, "R1 wrap", 80'(since_edge), 80'd4);
    pulse();
    quiet();
  endtask

  task automatic t_divisor();
    carrier_div = 8'd1;
    @(negedge clk);
    quiet();
    ivals[0] = 16; ivals[1] = 28; ivals[2] = 24;
    run_frame(3);
    expect_frame(3, "R1 divisor");
    carrier_div = 8'd3;
  endtask

  initial begin
    rst_n = 1'b0;
    carrier_div = 8'd3;
    field_in = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    quiet();
    t_boundaries();
    t_noise();
    t_empty();
    t_wrap_discard();
    t_long();
    t_since();
    t_divisor();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule